// File: doc/BRIEF.md
# Switchable-Depth UART Receive Buffer

This block holds characters that a UART receiver has already assembled, until software collects them through a register read. Each stored word is 12 bits: the character in bits 7:0 and four error tags above it (bit 8 framing, bit 9 parity, bit 10 break, bit 11 overrun). A control input selects between a 16-entry circular buffer and a single holding register. Any change of that input, in either direction, empties the buffer. The block drives the empty and full flags, a ready-to-accept indication and a receive-level interrupt request.

Each pop latches the error tags of the word it returns into a small receive-status register, and a clear strobe zeroes that register. While the single-register mode is active, a line-break event stores a marker word with only bit 10 set and records a break error in the status register. The serial deserializer, baud timing and bus decode sit outside the block.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, ready_o=1, rx_irq_o=0 and stat_o=0, and the single-register mode is in effect.
- R2: With fifo_en_i=1 the buffer holds 16 words and returns them in push order. full_o rises on the 16th stored word, and ready_o is 1 exactly while fewer than 16 words are held.
- R3: With fifo_en_i=0 the buffer holds one word. After a single push, full_o=1 and ready_o=0.
- R4: A push while the buffer is full is dropped, and the stored words and the returned data are unchanged.
- R5: A change of fifo_en_i flushes the buffer in that cycle, which leaves empty_o=1, full_o=0 and ready_o=1. Pushes, pops and break events in that cycle are ignored. The level of rx_irq_o is kept.
- R6: pop_data_o always shows the word at the read position. A pop of an empty buffer returns that stale slot and changes neither count nor position.
- R7: rx_irq_o rises when a push makes the count equal to 1. It falls when a pop leaves the count at 0, and this includes a pop of an already empty buffer.
- R8: brk_i, taken only in single-register mode, stores the word 12'h400 and sets stat_o[2]. In 16-entry mode it has no effect. If the buffer is full the marker is dropped, but stat_o[2] is still set.
- R9: A pop loads stat_o with bits 11:8 of the returned word. stat_clr_i zeroes stat_o and wins over a load or a break in the same cycle.
- R10: A push and a pop in the same cycle act as a pop followed by a push, so a full buffer accepts the new word and stays full.
- R11: A break and a push in the same cycle store the break marker and drop the pushed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects the 16-entry mode, 0 the single register |
| push_i | input | 1 | Store push_data_i |
| push_data_i | input | 12 | Received word: data 7:0, error tags 11:8 |
| brk_i | input | 1 | Line-break event |
| pop_i | input | 1 | Remove the word at the read position |
| pop_data_o | output | 12 | Word at the read position |
| stat_clr_i | input | 1 | Clear the receive-status register |
| stat_o | output | 4 | Error tags of the last popped word, plus the break record |
| ready_o | output | 1 | Buffer can take another word |
| empty_o | output | 1 | No word held |
| full_o | output | 1 | Held words equal the current depth |
| rx_irq_o | output | 1 | Receive-level interrupt request |

## Verification
The collision that matters most is a pop and a push in the same cycle. The bench provokes it at every fill level, including a full buffer and an empty one. It judges the flags, the interrupt and the order of later pops against the pop-then-push rule. The status register has a similar collision: a break, a pop and a clear strobe arrive in one cycle, and only the clear may prevail. A mode change that lands together with a push or a pop shows that the flush swallows both.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ERR_W   = 4;
  localparam int unsigned WORD_W  = DATA_W + ERR_W;
  localparam int unsigned BRK_BIT = 10;
  localparam int unsigned BRK_ERR = BRK_BIT - DATA_W;
  typedef logic [WORD_W-1:0] rx_word_t;
  localparam rx_word_t BRK_WORD = rx_word_t'(1) << BRK_BIT;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             push_i,
  input  logic             brk_i,
  input  logic             pop_i,
  output logic             pop_ok_o,
  output logic             brk_ok_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ready_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] TRIG_C = CNT_W'(TRIG);
  localparam logic [CNT_W-1:0] DEP_C  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] MSK_C  = PTR_W'(DEPTH - 1);

  logic             mode_q;
  logic [PTR_W-1:0] ptr_q, ptr_a;
  logic [CNT_W-1:0] cnt_q, cnt_a;
  logic             empty_q, empty_a, full_q, full_a, irq_q, irq_a;
  logic             flush;
  logic [PTR_W-1:0] mask;
  logic [CNT_W-1:0] eff_dep;

  assign mask    = mode_q ? MSK_C : '0;
  assign eff_dep = mode_q ? DEP_C : CNT_W'(1);
  assign flush   = fifo_en_i != mode_q;
  assign pop_ok_o = pop_i & ~flush;
  assign brk_ok_o = brk_i & ~mode_q & ~flush;

  // pop is applied first, then the incoming word
  always_comb begin
    cnt_a     = cnt_q;
    ptr_a     = ptr_q;
    empty_a   = empty_q;
    full_a    = full_q;
    irq_a     = irq_q;
    wr_en_o   = 1'b0;
    wr_slot_o = '0;
    if (flush) begin
      cnt_a   = '0;
      ptr_a   = '0;
      empty_a = 1'b1;
      full_a  = 1'b0;
    end else begin
      if (pop_ok_o) begin
        full_a = 1'b0;
        if (cnt_a != '0) begin
          cnt_a = cnt_a - CNT_W'(1);
          ptr_a = (ptr_a + PTR_W'(1)) & mask;
        end
        if (cnt_a == '0) empty_a = 1'b1;
        if (cnt_a + CNT_W'(1) == TRIG_C) irq_a = 1'b0;
      end
      wr_slot_o = (ptr_a + cnt_a[PTR_W-1:0]) & mask;
      if ((push_i | brk_ok_o) && (cnt_a < eff_dep)) begin
        wr_en_o = 1'b1;
        cnt_a   = cnt_a + CNT_W'(1);
        empty_a = 1'b0;
        if (cnt_a == eff_dep) full_a = 1'b1;
        if (cnt_a == TRIG_C) irq_a = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      mode_q  <= fifo_en_i;
      ptr_q   <= ptr_a;
      cnt_q   <= cnt_a;
      empty_q <= empty_a;
      full_q  <= full_a;
      irq_q   <= irq_a;
    end
  end

  assign rd_ptr_o = ptr_q;
  assign empty_o  = empty_q;
  assign full_o   = full_q;
  assign ready_o  = cnt_q < eff_dep;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 12,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_slot_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  wr_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign wr_sel[g] = wr_en_i && (wr_slot_i == PTR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) if (wr_sel[i]) mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
  parameter int unsigned ERR_W   = 4,
  parameter int unsigned BRK_ERR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_ok_i,
  input  logic [ERR_W-1:0] pop_err_i,
  input  logic             brk_ok_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] stat_o
);
  logic [ERR_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (pop_ok_i) stat_d = pop_err_i;
    if (brk_ok_i) stat_d[BRK_ERR] = 1'b1;
    if (clr_i) stat_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              brk_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] pop_data_o,
  input  logic              stat_clr_i,
  output logic [ERR_W-1:0]  stat_o,
  output logic              ready_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              rx_irq_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic             pop_ok, brk_ok, wr_en;
  logic [PTR_W-1:0] wr_slot, rd_ptr;
  rx_word_t         wr_data, rd_data;

  rxf_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fifo_en_i(fifo_en_i),
    .push_i   (push_i),
    .brk_i    (brk_i),
    .pop_i    (pop_i),
    .pop_ok_o (pop_ok),
    .brk_ok_o (brk_ok),
    .wr_en_o  (wr_en),
    .wr_slot_o(wr_slot),
    .rd_ptr_o (rd_ptr),
    .empty_o  (empty_o),
    .full_o   (full_o),
    .ready_o  (ready_o),
    .irq_o    (rx_irq_o)
  );

  // break marker displaces a coincident push
  assign wr_data = brk_ok ? BRK_WORD : push_data_i;

  rxf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_slot_i(wr_slot),
    .wr_data_i(wr_data),
    .rd_ptr_i (rd_ptr),
    .rd_data_o(rd_data)
  );

  rxf_status #(.ERR_W(ERR_W), .BRK_ERR(BRK_ERR)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pop_ok_i (pop_ok),
    .pop_err_i(rd_data[WORD_W-1:DATA_W]),
    .brk_ok_i (brk_ok),
    .clr_i    (stat_clr_i),
    .stat_o   (stat_o)
  );

  assign pop_data_o = rd_data;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk
  import uart_rx_fifo_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_i,
  input logic              push_i,
  input logic              brk_i,
  input logic              pop_i,
  input logic [WORD_W-1:0] pop_data_o,
  input logic              stat_clr_i,
  input logic [ERR_W-1:0]  stat_o,
  input logic              ready_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              rx_irq_o
);
  logic mode_m;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_m <= 1'b0;
    else         mode_m <= fifo_en_i;
  end

  p_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i != mode_m) |=> (empty_o && !full_o && ready_o));

  p_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_m && !empty_o) |-> (full_o && !ready_o));

  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && fifo_en_i == mode_m) |=> (full_o && $stable(pop_data_o)));

  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> $past(push_i || brk_i));

  p_irq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_o) |-> $past(pop_i));

  p_brk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !mode_m && !fifo_en_i && empty_o && !stat_clr_i)
      |=> (!empty_o && pop_data_o == BRK_WORD && stat_o[BRK_ERR]));

  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i |=> (stat_o == '0));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .push_i    (push_i),
  .brk_i     (brk_i),
  .pop_i     (pop_i),
  .pop_data_o(pop_data_o),
  .stat_clr_i(stat_clr_i),
  .stat_o    (stat_o),
  .ready_o   (ready_o),
  .empty_o   (empty_o),
  .full_o    (full_o),
  .rx_irq_o  (rx_irq_o)
);

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fifo_en_i = 1'b0;
  logic        push_i = 1'b0;
  logic [11:0] push_data_i = '0;
  logic        brk_i = 1'b0;
  logic        pop_i = 1'b0;
  logic        stat_clr_i = 1'b0;
  logic [11:0] pop_data_o;
  logic [3:0]  stat_o;
  logic        ready_o, empty_o, full_o, rx_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side expectation
  logic [11:0] mb [16];
  int          ptr_b = 0;
  int          cnt_b = 0;
  bit          mode_b = 1'b0;
  bit          irq_b = 1'b0;
  logic [3:0]  stat_b = '0;

  always #10 clk = ~clk;

  uart_rx_fifo uut (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .push_i(push_i),
    .push_data_i(push_data_i), .brk_i(brk_i), .pop_i(pop_i), .pop_data_o(pop_data_o),
    .stat_clr_i(stat_clr_i), .stat_o(stat_o), .ready_o(ready_o), .empty_o(empty_o),
    .full_o(full_o), .rx_irq_o(rx_irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    int dep;
    dep = mode_b ? 16 : 1;
    chk({tag, " empty"}, int'(empty_o), int'(cnt_b == 0));
    chk({tag, " full"},  int'(full_o),  int'(cnt_b == dep));
    chk({tag, " ready"}, int'(ready_o), int'(cnt_b < dep));
    chk({tag, " irq"},   int'(rx_irq_o), int'(irq_b));
    chk({tag, " stat"},  int'(stat_o),  int'(stat_b));
  endtask

  task automatic cyc(input string tag, input bit p, input logic [11:0] d,
                     input bit q, input bit b, input bit c);
    bit flush, bok, we;
    int dep;
    logic [11:0] wv;
    push_i = p; push_data_i = d; pop_i = q; brk_i = b; stat_clr_i = c;
    #1;
    flush = (fifo_en_i != mode_b);
    if (!flush) chk({tag, " pop_data"}, int'(pop_data_o), int'(mb[ptr_b]));
    if (flush) begin
      mode_b = fifo_en_i; ptr_b = 0; cnt_b = 0;
    end else begin
      dep = mode_b ? 16 : 1;
      if (q) begin
        stat_b = mb[ptr_b][11:8];
        if (cnt_b > 0) begin cnt_b--; ptr_b = (ptr_b + 1) % dep; end
        if (cnt_b == 0) irq_b = 1'b0;
      end
      bok = b && !mode_b;
      if (bok) stat_b[2] = 1'b1;
      wv = bok ? 12'h400 : d;
      we = (p || bok) && (cnt_b < dep);
      if (we) begin
        mb[(ptr_b + cnt_b) % dep] = wv;
        cnt_b++;
        if (cnt_b == 1) irq_b = 1'b1;
      end
    end
    if (c) stat_b = '0;
    @(negedge clk);
    chk_outs(tag);
    push_i = 1'b0; pop_i = 1'b0; brk_i = 1'b0; stat_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mb[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_outs("R1 reset");

    // enter 16-entry mode
    fifo_en_i = 1'b1;
    cyc("R5 flush on enable", 1'b1, 12'h0AA, 1'b0, 1'b0, 1'b0);

    // every fill level, overflow at the top, then drain including empty pop
    for (int n = 1; n <= 16; n++) begin
      for (int i = 0; i < n; i++)
        cyc("R2 R7 fill", 1'b1, 12'((n * 37 + i * 149) & 12'hfff), 1'b0, 1'b0, 1'b0);
      if (n == 16) cyc("R4 drop when full", 1'b1, 12'hABC, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < n; i++)
        cyc("R2 R9 drain", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
      cyc("R6 R7 empty pop", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
    end

    // simultaneous push and pop at each level
    for (int n = 0; n <= 16; n++) begin
      for (int i = 0; i < n; i++)
        cyc("R2 prefill", 1'b1, 12'((n * 11 + i) & 12'hfff), 1'b0, 1'b0, 1'b0);
      cyc("R10 push pop", 1'b1, 12'((n * 5 + 12'h300) & 12'hfff), 1'b1, 1'b0, 1'b0);
      cyc("R10 push pop again", 1'b1, 12'((n * 7 + 12'h900) & 12'hfff), 1'b1, 1'b0, 1'b0);
      for (int i = 0; i <= n; i++)
        cyc("R10 drain", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
    end

    // break ignored in 16-entry mode
    cyc("R8 break ignored", 1'b0, 12'h000, 1'b0, 1'b1, 1'b0);

    // flush to single mode with data held; irq kept
    for (int i = 0; i < 3; i++) cyc("R2 load", 1'b1, 12'(12'h120 + i), 1'b0, 1'b0, 1'b0);
    fifo_en_i = 1'b0;
    cyc("R5 flush keeps irq, push ignored", 1'b1, 12'h777, 1'b1, 1'b1, 1'b0);
    cyc("R6 R7 empty pop lowers irq", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);

    // single-register mode
    cyc("R3 single push", 1'b1, 12'h9C3, 1'b0, 1'b0, 1'b0);
    cyc("R3 R4 second push dropped", 1'b1, 12'h155, 1'b0, 1'b0, 1'b0);
    cyc("R9 pop latches error tags", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
    cyc("R9 clear", 1'b0, 12'h000, 1'b0, 1'b0, 1'b1);
    cyc("R8 break stores marker", 1'b0, 12'h000, 1'b0, 1'b1, 1'b0);
    cyc("R8 break when full", 1'b0, 12'h000, 1'b0, 1'b1, 1'b1);
    cyc("R8 break when full sets stat", 1'b0, 12'h000, 1'b0, 1'b1, 1'b0);
    cyc("R8 pop marker", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
    cyc("R11 break beats push", 1'b1, 12'h0F0, 1'b0, 1'b1, 1'b0);
    cyc("R9 clear beats pop", 1'b0, 12'h000, 1'b1, 1'b0, 1'b1);
    cyc("R10 single push pop", 1'b1, 12'hE42, 1'b1, 1'b0, 1'b0);
    cyc("R10 single push pop full", 1'b1, 12'h233, 1'b1, 1'b0, 1'b0);
    cyc("R9 clear beats break", 1'b0, 12'h000, 1'b1, 1'b1, 1'b1);
    cyc("R6 pop", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
    cyc("R6 R9 stale pop", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);

    // back to 16-entry mode: flush ignores the pop
    fifo_en_i = 1'b1;
    cyc("R5 flush ignores pop", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
    cyc("R2 push after flush", 1'b1, 12'h812, 1'b0, 1'b0, 1'b0);
    cyc("R2 pop after flush", 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule